// File: doc/BRIEF.md
# Infrared Receive/Transmit FIFO Interrupt Controller

This block sits between an infrared pulse sampler, an infrared transmitter and a small register bus. It buffers sample bytes from the sampler in a receive FIFO and buffers bytes that software writes for transmission in a transmit FIFO. It keeps an eight-bit sticky event register whose bits are cleared by writing ones. It also keeps an enable register with the same bit layout, and drives one interrupt line.

Software services the block from an interrupt handler. The handler reads the event register and the enable register and ANDs them. A zero result tells the handler that the interrupt on a shared line came from another source. The handler then writes the pending bits back to clear them, reads the receive count, and pops that many bytes from the data port.

The sampler side has no back-pressure: `smp_valid` is a one-cycle offer with no ready. A byte offered while the receive FIFO is full is lost and recorded as an overrun. The transmit side is a valid/ready stream. `tx_valid` is high whenever the transmit FIFO holds a byte, and a byte leaves on a cycle with `tx_valid` and `tx_ready` both high. The transmitter raises `tx_ready` only when it needs a byte.

Top module: `cir_fifo_irq_ctrl`

## Requirements
- R1: After reset, the event register, the enable register, the control register and both FIFO counts read 0, `irq` is low and `tx_valid` is low.
- R2: A `smp_valid` offer while the receive FIFO (depth 32) is not full stores the byte and sets event bit 7 (data ready). Reads of address 4 return the stored bytes oldest first, and each read pops one byte. A read of address 4 while the FIFO is empty returns 0 and changes nothing.
- R3: An offer while the receive FIFO holds 32 bytes discards the byte, leaves the count at 32 and sets both event bit 4 (overrun) and event bit 7.
- R4: Event bit 6 is set when an accepted byte brings the receive count to at least the receive trigger level. The level comes from control bits [5:4]: code 0 gives 1, 1 gives 8, 2 gives 16, 3 gives 24.
- R5: A one-cycle `pkt_end` pulse sets event bit 5, and a one-cycle `min_len` pulse sets event bit 0.
- R6: A write to address 0 clears each event bit whose data bit is 1 and keeps the others. Writing 0xFF clears every bit. If an event sets a bit in the same cycle as the clear, the set wins.
- R7: `irq` is high exactly when some bit is set in both the event register and the enable register (address 1, same bit positions).
- R8: A write to address 2 with bit 0 set empties the receive FIFO, and with bit 1 set empties the transmit FIFO. Both clear bits act in that cycle only and read back as 0. The trigger fields take the written value and the event register is untouched. A byte offered in the same cycle as a receive clear is discarded without setting any event bit.
- R9: Address 3 reads the receive byte count, and address 6 reads the transmit byte count.
- R10: Writes to address 5 append to the transmit FIFO (depth 16). A write is dropped when the FIFO is full. `tx_data` shows the oldest byte while `tx_valid` is high.
- R11: A transfer that removes the last transmit byte sets event bit 3. A transfer that leaves the transmit count at or below the transmit level sets event bit 2; the level is control bits [3:2] times 4. `tx_ready` high while the transmit FIFO is empty sets event bit 1 (underrun).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample byte offered this cycle (no back-pressure) |
| smp_data | input | 8 | Sample byte |
| pkt_end | input | 1 | One-cycle packet-end event from the sampler |
| min_len | input | 1 | One-cycle minimum-length event from the sampler |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle of the strobe |
| tx_valid | output | 1 | Transmit FIFO holds a byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Transmitter takes a byte this cycle |
| irq | output | 1 | Interrupt, high while an enabled event is pending |

## Verification
Most internal faults show up at the ports within one clock. A wrong FIFO pointer or count appears at the next read of the count register or of the data port. A wrong event bit appears on `irq` in the cycle after the event whenever that bit is enabled. The bench compares `irq`, `tx_valid` and `tx_data` with a behavioural model on every clock, and it compares every register read in the cycle of the strobe. It enables individual event bits so that a flag set or cleared on the wrong cycle is visible at once. Overrun behaviour is checked by filling the receive FIFO to the boundary and offering bytes past it.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  // register map
  localparam logic [AW-1:0] A_EVT   = 3'd0;
  localparam logic [AW-1:0] A_IEN   = 3'd1;
  localparam logic [AW-1:0] A_CTRL  = 3'd2;
  localparam logic [AW-1:0] A_RXCNT = 3'd3;
  localparam logic [AW-1:0] A_RXDAT = 3'd4;
  localparam logic [AW-1:0] A_TXDAT = 3'd5;
  localparam logic [AW-1:0] A_TXCNT = 3'd6;

  // event bit positions (software decodes these)
  localparam int EV_RXRDY  = 7;
  localparam int EV_RXTRIG = 6;
  localparam int EV_PKTEND = 5;
  localparam int EV_RXOVF  = 4;
  localparam int EV_TXEMP  = 3;
  localparam int EV_TXTRIG = 2;
  localparam int EV_TXUND  = 1;
  localparam int EV_MINLEN = 0;

  // control bit positions
  localparam int CT_RXCLR = 0;
  localparam int CT_TXCLR = 1;
  localparam int CT_TXLVL = 2;
  localparam int CT_RXLVL = 4;

  // receive trigger level: code 0 means a single byte, else quarters of depth
  function automatic int unsigned rx_level(logic [1:0] code, int unsigned depth);
    return (code == 2'd0) ? 1 : int'(code) * (depth / 4);
  endfunction

  // transmit trigger level: quarters of depth, code 0 means empty
  function automatic int unsigned tx_level(logic [1:0] code, int unsigned depth);
    return int'(code) * (depth / 4);
  endfunction
endpackage

// File: rtl/cirq_fifo.sv
module cirq_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + PW'(1);
      if (do_pop)  rp <= rp + PW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + ONE;
        2'b01:   count <= count - ONE;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cirq_evt.sv
module cirq_evt #(
  parameter int RX_CW = 6,
  parameter int TX_CW = 5
) (
  input  logic             smp_valid,
  input  logic             rx_full,
  input  logic             rx_clr,
  input  logic [RX_CW-1:0] rx_count,
  input  logic [RX_CW-1:0] rx_lvl,
  input  logic             tx_ready,
  input  logic             tx_empty,
  input  logic             tx_clr,
  input  logic [TX_CW-1:0] tx_count,
  input  logic [TX_CW-1:0] tx_lvl,
  input  logic             pkt_end,
  input  logic             min_len,
  output logic [7:0]       ev_set
);
  import cirq_pkg::*;

  logic             rx_acc, rx_ovf, rx_reach;
  logic             tx_take, tx_drain, tx_low;
  logic [RX_CW:0]   rx_after;
  logic [TX_CW:0]   tx_lvl_p1;

  assign rx_acc    = smp_valid && !rx_full && !rx_clr;
  assign rx_ovf    = smp_valid &&  rx_full && !rx_clr;
  assign rx_after  = {1'b0, rx_count} + {{RX_CW{1'b0}}, 1'b1};
  assign rx_reach  = rx_acc && (rx_after >= {1'b0, rx_lvl});

  assign tx_take   = tx_ready && !tx_empty && !tx_clr;
  assign tx_lvl_p1 = {1'b0, tx_lvl} + {{TX_CW{1'b0}}, 1'b1};
  assign tx_drain  = tx_take && (tx_count == TX_CW'(1));
  assign tx_low    = tx_take && ({1'b0, tx_count} <= tx_lvl_p1);

  always_comb begin
    ev_set            = '0;
    ev_set[EV_RXRDY]  = rx_acc || rx_ovf;
    ev_set[EV_RXTRIG] = rx_reach;
    ev_set[EV_PKTEND] = pkt_end;
    ev_set[EV_RXOVF]  = rx_ovf;
    ev_set[EV_TXEMP]  = tx_drain;
    ev_set[EV_TXTRIG] = tx_low;
    ev_set[EV_TXUND]  = tx_ready && tx_empty;
    ev_set[EV_MINLEN] = min_len;
  end
endmodule

// File: rtl/cirq_status.sv
module cirq_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_set,
  input  logic         w1c_en,
  input  logic [W-1:0] w1c_mask,
  input  logic         ien_we,
  input  logic [W-1:0] ien_d,
  output logic [W-1:0] evt,
  output logic [W-1:0] ien,
  output logic         irq
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        evt[i] <= 1'b0;
      else if (ev_set[i])
        evt[i] <= 1'b1;
      else if (w1c_en && w1c_mask[i])
        evt[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ien <= '0;
    else if (ien_we) ien <= ien_d;
  end

  assign irq = |(evt & ien);
endmodule

// File: rtl/cir_fifo_irq_ctrl.sv
module cir_fifo_irq_ctrl #(
  parameter int RX_DEPTH = 32,
  parameter int TX_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_valid,
  input  logic [7:0] smp_data,
  input  logic       pkt_end,
  input  logic       min_len,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       irq
);
  import cirq_pkg::*;

  localparam int RX_CW = $clog2(RX_DEPTH+1);
  localparam int TX_CW = $clog2(TX_DEPTH+1);

  logic             wr_evt, wr_ien, wr_ctrl, wr_tx, rd_rx;
  logic             rx_clr, tx_clr;
  logic [1:0]       rx_code, tx_code;
  logic [RX_CW-1:0] rx_count, rx_lvl;
  logic [TX_CW-1:0] tx_count, tx_lvl;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic [DW-1:0]    rx_dout;
  logic [7:0]       ev_set, evt, ien;

  assign wr_evt  = reg_wr && (reg_addr == A_EVT);
  assign wr_ien  = reg_wr && (reg_addr == A_IEN);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_tx   = reg_wr && (reg_addr == A_TXDAT);
  assign rd_rx   = reg_rd && (reg_addr == A_RXDAT);
  assign rx_clr  = wr_ctrl && reg_wdata[CT_RXCLR];
  assign tx_clr  = wr_ctrl && reg_wdata[CT_TXCLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_code <= '0;
      tx_code <= '0;
    end else if (wr_ctrl) begin
      rx_code <= reg_wdata[CT_RXLVL +: 2];
      tx_code <= reg_wdata[CT_TXLVL +: 2];
    end
  end

  assign rx_lvl = RX_CW'(rx_level(rx_code, RX_DEPTH));
  assign tx_lvl = TX_CW'(tx_level(tx_code, TX_DEPTH));

  cirq_fifo #(.DEPTH(RX_DEPTH), .W(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(smp_valid), .din(smp_data), .pop(rd_rx),
    .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  cirq_fifo #(.DEPTH(TX_DEPTH), .W(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(wr_tx), .din(reg_wdata), .pop(tx_ready),
    .dout(tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  assign tx_valid = !tx_empty;

  cirq_evt #(.RX_CW(RX_CW), .TX_CW(TX_CW)) u_evt (
    .smp_valid(smp_valid), .rx_full(rx_full), .rx_clr(rx_clr),
    .rx_count(rx_count), .rx_lvl(rx_lvl),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_clr(tx_clr),
    .tx_count(tx_count), .tx_lvl(tx_lvl),
    .pkt_end(pkt_end), .min_len(min_len), .ev_set(ev_set)
  );

  cirq_status #(.W(8)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set),
    .w1c_en(wr_evt), .w1c_mask(reg_wdata),
    .ien_we(wr_ien), .ien_d(reg_wdata),
    .evt(evt), .ien(ien), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EVT:   reg_rdata = evt;
      A_IEN:   reg_rdata = ien;
      A_CTRL:  reg_rdata = {2'b00, rx_code, tx_code, 2'b00};
      A_RXCNT: reg_rdata = 8'(rx_count);
      A_RXDAT: reg_rdata = rx_empty ? '0 : rx_dout;
      A_TXCNT: reg_rdata = 8'(tx_count);
      default: reg_rdata = '0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = tx_full;
endmodule

// File: rtl/cirq_chk.sv
module cirq_chk #(
  parameter int RX_DEPTH = 32,
  parameter int RX_CW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             pkt_end,
  input logic             min_len,
  input logic             tx_ready,
  input logic             tx_valid,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             rx_full,
  input logic [RX_CW-1:0] rx_count,
  input logic [7:0]       evt,
  input logic [7:0]       ien,
  input logic             irq
);
  logic rxclr_w, rxpop_w;
  assign rxclr_w = reg_wr && (reg_addr == 3'd2) && reg_wdata[0];
  assign rxpop_w = reg_rd && (reg_addr == 3'd4);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= RX_CW'(RX_DEPTH));

  p_ovf_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && rx_full && !rxclr_w) |=> (evt[7] && evt[4]));

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rxpop_w && !rxclr_w) |=> rx_full);

  p_pkt_end_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && ien[5] && !(reg_wr && reg_addr == 3'd1)) |=> irq);

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata == 8'hFF &&
     !smp_valid && !pkt_end && !min_len && !tx_ready) |=> (evt == 8'h00));

  p_no_enable_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 8'h00) |-> !irq);

  p_rx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rxclr_w |=> (rx_count == '0));

  p_underrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> evt[1]);
endmodule

bind cir_fifo_irq_ctrl cirq_chk #(.RX_DEPTH(RX_DEPTH), .RX_CW(RX_CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .pkt_end(pkt_end),
  .min_len(min_len), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rx_full(rx_full), .rx_count(rx_count), .evt(evt), .ien(ien), .irq(irq)
);

// File: tb/tb_cir_fifo_irq_ctrl.sv
module tb_cir_fifo_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 0, pkt_end = 0, min_len = 0, reg_wr = 0, reg_rd = 0, tx_ready = 0;
  logic [7:0] smp_data = 0, reg_wdata = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_rdata, tx_data;
  logic tx_valid, irq;

  always #10 clk = ~clk;  // 50 MHz

  cir_fifo_irq_ctrl dut (.*);

  int total = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  byte unsigned rxq[$], txq[$];
  int m_evt = 0, m_ien = 0, m_rxc = 0, m_txc = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int m_read(logic [2:0] a);
    case (a)
      3'd0: return m_evt;
      3'd1: return m_ien;
      3'd2: return (m_rxc << 4) | (m_txc << 2);
      3'd3: return rxq.size();
      3'd4: return (rxq.size() > 0) ? int'(rxq[0]) : 0;
      3'd6: return txq.size();
      default: return 0;
    endcase
  endfunction

  function automatic void m_step(bit sv, byte unsigned sd, bit pe, bit ml, bit tr,
                                 bit wr, bit rd, logic [2:0] a, byte unsigned wd);
    int setv = 0;
    int rxlvl = (m_rxc == 0) ? 1 : m_rxc * 8;
    int txlvl = m_txc * 4;
    bit rxclr = wr && a == 3'd2 && wd[0];
    bit txclr = wr && a == 3'd2 && wd[1];
    int rxs = rxq.size(), txs = txq.size();
    if (tr && txs == 0) setv |= 8'h02;
    if (tr && txs > 0 && !txclr) begin
      void'(txq.pop_front());
      if (txs == 1) setv |= 8'h08;
      if (txs - 1 <= txlvl) setv |= 8'h04;
    end
    if (rd && a == 3'd4 && rxs > 0 && !rxclr) void'(rxq.pop_front());
    if (sv && !rxclr) begin
      if (rxs == 32) setv |= 8'h90;
      else begin
        setv |= 8'h80;
        if (rxs + 1 >= rxlvl) setv |= 8'h40;
        rxq.push_back(sd);
      end
    end
    if (wr && a == 3'd5 && !txclr && txs < 16) txq.push_back(wd);
    if (pe) setv |= 8'h20;
    if (ml) setv |= 8'h01;
    if (wr && a == 3'd0) m_evt &= ~int'(wd);
    m_evt |= setv;
    if (wr && a == 3'd1) m_ien = wd;
    if (wr && a == 3'd2) begin m_rxc = wd[5:4]; m_txc = wd[3:2]; end
    if (rxclr) rxq.delete();
    if (txclr) txq.delete();
  endfunction

  // one clock: drive at negedge, check reads before the edge, compare after it
  task automatic tick(bit sv, byte unsigned sd, bit pe, bit ml, bit tr,
                      bit wr, bit rd, logic [2:0] a, byte unsigned wd, string tag);
    smp_valid = sv; smp_data = sd; pkt_end = pe; min_len = ml; tx_ready = tr;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    #1;
    if (rd) chk(tag, int'(reg_rdata), m_read(a));
    m_step(sv, sd, pe, ml, tr, wr, rd, a, wd);
    @(posedge clk);
    @(negedge clk);
    smp_valid = 0; pkt_end = 0; min_len = 0; tx_ready = 0; reg_wr = 0; reg_rd = 0;
    chk("R7 irq", int'(irq), int'((m_evt & m_ien) != 0));
    chk("R10 tx_valid", int'(tx_valid), int'(txq.size() > 0));
    if (txq.size() > 0) chk("R10 tx_data", int'(tx_data), int'(txq[0]));
  endtask

  task automatic idle(); tick(0,0,0,0,0,0,0,0,0,""); endtask
  task automatic wreg(logic [2:0] a, byte unsigned d); tick(0,0,0,0,0,1,0,a,d,""); endtask
  task automatic rreg(logic [2:0] a, string tag); tick(0,0,0,0,0,0,1,a,0,tag); endtask
  task automatic samp(byte unsigned d); tick(1,d,0,0,0,0,0,0,0,""); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    for (int a = 0; a < 7; a++) if (a != 5) rreg(3'(a), "R1 reset read");

    // R2 store order, data ready, pop, empty read
    samp(8'h91); samp(8'h12); samp(8'hA3);
    rreg(3'd0, "R2/R4 events after samples");
    rreg(3'd3, "R9 rx count");
    for (int i = 0; i < 3; i++) tick(0,0,0,0,0,0,1,3'd4,0,"R2 rx data order");
    tick(0,0,0,0,0,0,1,3'd4,0,"R2 empty read is 0");
    rreg(3'd3, "R2 count after pops");

    // R6 partial and full clear
    wreg(3'd0, 8'h40); rreg(3'd0, "R6 partial clear");
    wreg(3'd0, 8'hFF); rreg(3'd0, "R6 clear all");

    // R4 trigger level 16
    wreg(3'd2, 8'h20); rreg(3'd2, "R8 ctrl readback");
    for (int i = 0; i < 15; i++) samp(8'(i));
    wreg(3'd0, 8'h80);
    rreg(3'd0, "R4 no trigger at 15");
    samp(8'h55); rreg(3'd0, "R4 trigger at 16");

    // R3 fill and overrun
    for (int i = 0; i < 16; i++) samp(8'(8'h60 + i));
    wreg(3'd0, 8'hFF);
    rreg(3'd3, "R3 count full");
    samp(8'hEE); samp(8'hEF);
    rreg(3'd0, "R3 overrun and ready");
    rreg(3'd3, "R3 count held at 32");
    tick(1,8'h77,0,0,0,0,1,3'd4,0,"R3 pop and offer while full");
    rreg(3'd3, "R3 count after pop with offer");

    // R8 receive clear, same-cycle offer discarded
    wreg(3'd0, 8'hFF);
    tick(1,8'h33,0,0,0,1,0,3'd2,8'h21,"");
    rreg(3'd3, "R8 rx cleared");
    rreg(3'd2, "R8 clear bit reads 0");
    rreg(3'd0, "R8 no flags from discarded byte");

    // R5 / R7 sampler events and enables
    wreg(3'd1, 8'h20);
    tick(0,0,1,0,0,0,0,0,0,"");
    rreg(3'd0, "R5 packet end");
    wreg(3'd1, 8'h01); idle();
    tick(0,0,0,1,0,0,0,0,0,"");
    rreg(3'd0, "R5 min length");
    tick(0,0,1,0,0,1,0,3'd0,8'h20,"");
    rreg(3'd0, "R6 set wins over clear");
    wreg(3'd0, 8'hFF); wreg(3'd1, 8'hFF); idle();

    // R10 / R11 transmit
    wreg(3'd2, 8'h24);
    for (int i = 0; i < 5; i++) wreg(3'd5, 8'(8'hC0 + i));
    rreg(3'd6, "R9 tx count");
    tick(0,0,0,0,1,0,0,0,0,"");
    rreg(3'd0, "R11 tx level reached");
    wreg(3'd0, 8'hFF);
    for (int i = 0; i < 4; i++) tick(0,0,0,0,1,0,0,0,0,"");
    rreg(3'd0, "R11 tx drained");
    wreg(3'd0, 8'hFF);
    tick(0,0,0,0,1,0,0,0,0,"");
    rreg(3'd0, "R11 underrun");
    for (int i = 0; i < 17; i++) wreg(3'd5, 8'(i));
    rreg(3'd6, "R10 tx full drops");
    wreg(3'd2, 8'h02);
    rreg(3'd6, "R8 tx cleared");
    rreg(3'd2, "R8 ctrl after tx clear");
    idle();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule